// File: doc/BRIEF.md
# I2C Byte-Level Master Engine

This block is the master side of an I2C port. It works one byte at a time. A host loads a byte into the write-data input. It then pulses `go_i` together with three control bits: a start request, a stop request and a negative-acknowledge request. The engine turns each accepted command into bus activity. That activity is an optional START, or a repeated START when the engine already owns the bus. Then come eight data bits (MSB first) and the ninth acknowledge bit. An optional STOP closes the command.

After reset the unit sits in slave-receive (idle) mode with both lines released. A START command puts it into master-transmit mode while it sends the address byte. When that byte completes, bit 0 of the byte chooses the next mode: 0 keeps master-transmit, 1 selects master-receive. Between bytes the engine holds SCL low and waits for the next command. A STOP ends the transfer and returns the unit to idle. The SCL and SDA outputs are open-drain enables: 1 pulls the line low. Every bus phase lasts `div_i` system clocks, and `div_i` must be at least 2.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, `scl_oe_o`=0, `sda_oe_o`=0, `done_o`=0, `busy_o`=0 and `mode_o`=0 (0 = slave-receive idle, 1 = master-transmit, 2 = master-receive).
- R2: In idle, a command with start=1 and stop=0 produces a START (SDA falls while SCL is high) and then sends the byte MSB first. `done_o` rises 19·`div_i` clocks after the accepting edge. After that byte, `mode_o` is 1 if byte bit 0 was 0, and 2 if it was 1.
- R3: While the bus is owned, a command with start=0 and stop=0 moves one byte with no START or STOP. `done_o` rises 18·`div_i` clocks after the accepting edge.
- R4: While the bus is owned, a command with start=1 and stop=0 produces a repeated START without any STOP. `done_o` rises 21·`div_i` clocks after the accepting edge.
- R5: In master-transmit mode the engine releases SDA during the ninth clock. At done, `ack_rx_o` holds the SDA level sampled then (0 = acknowledged, 1 = not acknowledged).
- R6: In master-receive mode with stop=0, the received byte (first bus bit as bit 7) appears on `rd_data_o` at done. The ninth bit is driven from the nack control bit: 0 pulls SDA low, 1 leaves it high.
- R7: With stop=1 the start bit is ignored. The byte is sent (transmit) or received (receive), and in receive mode a NACK is always given. A STOP follows (SDA rises while SCL is high). `done_o` rises 21·`div_i` clocks after the accepting edge, and then `mode_o` is 0 with both lines released.
- R8: `go_i` has no effect while `busy_o`=1. In idle it has no effect unless start=1 and stop=0.
- R9: SDA changes while SCL stays high only as a START or a STOP.
- R10: `done_o` is a single-cycle pulse after every completed command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | DIV_W | System clocks per bus phase (at least 2) |
| go_i | input | 1 | Command strobe |
| ctl_start_i | input | 1 | Request START / repeated START before the byte |
| ctl_stop_i | input | 1 | Request STOP after the byte (overrides start) |
| ctl_nack_i | input | 1 | Receive mode: 1 answers the byte with NACK |
| wr_data_i | input | DATA_W | Byte to transmit (address in 7:1, direction in 0 for START) |
| rd_data_o | output | DATA_W | Last received byte |
| ack_rx_o | output | 1 | Acknowledge level sampled after a transmitted byte |
| done_o | output | 1 | One-cycle pulse when a command completes |
| busy_o | output | 1 | Command in progress |
| mode_o | output | 2 | 0 idle slave-receive, 1 master-transmit, 2 master-receive |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
Two functions can fall together at the final phase of a byte. One is reporting the byte's end through `done_o`. The other is acting on a STOP or a new command, whose `go_i` may already arrive while the engine is busy. The bench provokes this by pulsing a START command in the middle of a running byte. It then requires that exactly one done arrives, at the arithmetic 18·`div_i` time, and that the modelled slave sees no extra START. It also runs receive-with-STOP with the nack control bit cleared, and judges from the slave side that a NACK and then a STOP still occur. The sweep repeats every sequence for `div_i` of 2, 3 and 4.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  typedef enum logic [1:0] {
    MODE_SLV_RX = 2'd0,
    MODE_M_TX   = 2'd1,
    MODE_M_RX   = 2'd2
  } bm_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HOLD, ST_RS0, ST_RS1, ST_START,
    ST_BLO, ST_BHI, ST_P0, ST_P1, ST_P2
  } bm_state_e;
endpackage

// File: rtl/i2c_bm_tick.sv
module i2c_bm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/i2c_bm_shreg.sv
module i2c_bm_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] data,
  output logic         msb
);
  always_ff @(posedge clk) begin
    if (rst)        data <= '0;
    else if (load)  data <= load_val;
    else if (shift) data <= {data[W-2:0], sin};
  end

  assign msb = data[W-1];
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              go_i,
  input  logic              ctl_start_i,
  input  logic              ctl_stop_i,
  input  logic              ctl_nack_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              ack_rx_o,
  output logic              done_o,
  output logic              busy_o,
  output logic [1:0]        mode_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              sda_i
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] ACK_IDX = CNT_W'(DATA_W);

  bm_state_e        st_q, st_d;
  bm_mode_e         mode_q;
  logic [CNT_W-1:0] bit_q;
  logic             c_stop_q, c_nack_q, c_addr_q, c_dir_q;
  logic             tick, run, go_ok, ack_bit, is_tx, drv_low;
  logic             sh_en, sh_msb;
  logic [DATA_W-1:0] sh_data;
  logic             scl_c, sda_c;
  logic             want_start;

  assign run        = (st_q != ST_IDLE) && (st_q != ST_HOLD);
  assign busy_o     = run;
  assign mode_o     = mode_q;
  assign ack_bit    = (bit_q == ACK_IDX);
  assign is_tx      = (mode_q == MODE_M_TX);
  assign want_start = ctl_start_i && !ctl_stop_i;
  assign sh_en      = (st_q == ST_BHI) && tick && !ack_bit;

  i2c_bm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(run), .div(div_i), .tick(tick)
  );

  i2c_bm_shreg #(.W(DATA_W)) u_shreg (
    .clk(clk), .rst(rst), .load(go_ok), .load_val(wr_data_i),
    .shift(sh_en), .sin(sda_i), .data(sh_data), .msb(sh_msb)
  );

  // SDA pull for the current bit: data bits when sending, ack bit when receiving
  assign drv_low = ack_bit ? (!is_tx && !(c_nack_q || c_stop_q))
                           : (is_tx && !sh_msb);

  always_comb begin
    st_d  = st_q;
    go_ok = 1'b0;
    unique case (st_q)
      ST_IDLE: if (go_i && want_start) begin go_ok = 1'b1; st_d = ST_START; end
      ST_HOLD: if (go_i) begin
                 go_ok = 1'b1;
                 st_d  = want_start ? ST_RS0 : ST_BLO;
               end
      ST_RS0:  if (tick) st_d = ST_RS1;
      ST_RS1:  if (tick) st_d = ST_START;
      ST_START:if (tick) st_d = ST_BLO;
      ST_BLO:  if (tick) st_d = ST_BHI;
      ST_BHI:  if (tick) st_d = !ack_bit ? ST_BLO : (c_stop_q ? ST_P0 : ST_HOLD);
      ST_P0:   if (tick) st_d = ST_P1;
      ST_P1:   if (tick) st_d = ST_P2;
      ST_P2:   if (tick) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_q)
      ST_IDLE:  begin scl_c = 1'b0; sda_c = 1'b0;    end
      ST_HOLD:  begin scl_c = 1'b1; sda_c = 1'b0;    end
      ST_RS0:   begin scl_c = 1'b1; sda_c = 1'b0;    end
      ST_RS1:   begin scl_c = 1'b0; sda_c = 1'b0;    end
      ST_START: begin scl_c = 1'b0; sda_c = 1'b1;    end
      ST_BLO:   begin scl_c = 1'b1; sda_c = drv_low; end
      ST_BHI:   begin scl_c = 1'b0; sda_c = drv_low; end
      ST_P0:    begin scl_c = 1'b1; sda_c = 1'b1;    end
      ST_P1:    begin scl_c = 1'b0; sda_c = 1'b1;    end
      ST_P2:    begin scl_c = 1'b0; sda_c = 1'b0;    end
      default:  begin scl_c = 1'b0; sda_c = 1'b0;    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      mode_q    <= MODE_SLV_RX;
      bit_q     <= '0;
      c_stop_q  <= 1'b0;
      c_nack_q  <= 1'b0;
      c_addr_q  <= 1'b0;
      c_dir_q   <= 1'b0;
      done_o    <= 1'b0;
      ack_rx_o  <= 1'b0;
      rd_data_o <= '0;
      scl_oe_o  <= 1'b0;
      sda_oe_o  <= 1'b0;
    end else begin
      st_q     <= st_d;
      done_o   <= 1'b0;
      scl_oe_o <= scl_c;
      sda_oe_o <= sda_c;
      if (go_ok) begin
        c_stop_q <= ctl_stop_i;
        c_nack_q <= ctl_nack_i;
        c_addr_q <= want_start;
        c_dir_q  <= wr_data_i[0];
        bit_q    <= '0;
        if (want_start) mode_q <= MODE_M_TX;
      end
      if (st_q == ST_BHI && tick) begin
        if (ack_bit) begin
          if (is_tx) ack_rx_o  <= sda_i;
          else       rd_data_o <= sh_data;
          if (!c_stop_q) begin
            done_o <= 1'b1;
            if (c_addr_q) mode_q <= c_dir_q ? MODE_M_RX : MODE_M_TX;
          end
        end else begin
          bit_q <= bit_q + CNT_W'(1);
        end
      end
      if (st_q == ST_P2 && tick) begin
        done_o <= 1'b1;
        mode_q <= MODE_SLV_RX;
      end
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && $past(st_q) == ST_IDLE) |-> (!scl_oe_o && !sda_oe_o));

  // R9
  sda_high_scl_chk: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe_o && !$past(scl_oe_o) && (sda_oe_o != $past(sda_oe_o)))
      |-> ($past(st_q) == ST_START || $past(st_q) == ST_P2));

  // R7
  idle_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> (mode_o == 2'd0));

  // R7
  rx_stop_nack_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(st_q) == ST_BLO && $past(bit_q) == ACK_IDX &&
     $past(mode_q) == MODE_M_RX && $past(c_stop_q)) |-> !sda_oe_o);
endmodule

// File: tb/i2c_byte_master_tb.sv
`timescale 1ns/1ps
module i2c_byte_master_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] div = 8'd2;
  logic       go = 1'b0, cs = 1'b0, cp = 1'b0, cn = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd_data;
  logic       ack_rx, done, busy, scl_oe, sda_oe;
  logic [1:0] mode;

  logic       pull;
  logic       scl_l, sda_l;
  int         checks = 0, failures = 0;
  bit         finished = 0;

  // slave model state
  int         cnt, starts, stops;
  bit         first, rd_mode, next_rd, in_xfer, m_ack, ack_en;
  logic [7:0] sh, last_byte, slave_tx;
  logic       pscl, psda;

  always #2 clk = ~clk;

  assign scl_l = ~scl_oe;
  assign sda_l = ~(sda_oe | pull);

  i2c_byte_master u_dut (
    .clk(clk), .rst(rst), .div_i(div), .go_i(go), .ctl_start_i(cs),
    .ctl_stop_i(cp), .ctl_nack_i(cn), .wr_data_i(wd), .rd_data_o(rd_data),
    .ack_rx_o(ack_rx), .done_o(done), .busy_o(busy), .mode_o(mode),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda_l)
  );

  always_comb begin
    pull = 1'b0;
    if (in_xfer && cnt == 8 && (first || !rd_mode) && ack_en) pull = 1'b1;
    else if (in_xfer && !first && rd_mode && cnt >= 0 && cnt < 8)
      pull = !slave_tx[3'(7 - cnt)];
  end

  always @(negedge clk) begin
    if (rst) begin
      cnt = -1; first = 0; rd_mode = 0; next_rd = 0; in_xfer = 0; m_ack = 0;
      sh = 0; last_byte = 0; starts = 0; stops = 0; pscl = 1; psda = 1;
    end else begin
      if (pscl && scl_l && psda && !sda_l) begin
        starts++; cnt = -1; first = 1; in_xfer = 1;
      end else if (pscl && scl_l && !psda && sda_l) begin
        stops++; in_xfer = 0; rd_mode = 0; cnt = -1;
      end else if (!pscl && scl_l && in_xfer && cnt >= 0) begin
        if (cnt < 8) sh = {sh[6:0], sda_l};
        else begin
          last_byte = sh;
          if (first) next_rd = sh[0];
          else if (rd_mode) begin m_ack = sda_l; next_rd = !sda_l; end
          else next_rd = 0;
        end
      end else if (pscl && !scl_l && in_xfer) begin
        if (cnt == 8) begin cnt = 0; first = 0; rd_mode = next_rd; end
        else cnt++;
      end
      pscl = scl_l; psda = sda_l;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // issue one command; n = clocks from accepting edge to done; d2 = done one cycle later
  task automatic run_go(input bit s, input bit p, input bit k, input logic [7:0] d,
                        input int poke, output int n, output int d2);
    @(negedge clk); cs = s; cp = p; cn = k; wd = d; go = 1;
    @(posedge clk); #1 go = 0;
    n = 0;
    while (n < 100 * int'(div)) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == poke) begin go = 1; cs = 1; cp = 0; end else go = 0;
      if (done) break;
    end
    @(negedge clk); d2 = int'(done); go = 0;
    @(negedge clk);
  endtask

  initial begin
    int n, d2, seen;
    ack_en = 1; slave_tx = 8'h00;
    for (int dv = 2; dv <= 4; dv++) begin
      div = 8'(dv); rst = 1;
      repeat (4) @(negedge clk);
      rst = 0;
      @(negedge clk);
      // R1 reset state
      chk("R1 scl_oe", int'(scl_oe), 0);
      chk("R1 sda_oe", int'(sda_oe), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 busy", int'(busy), 0);
      chk("R1 mode", int'(mode), 0);

      // R8 idle commands without a plain START are ignored
      seen = 0;
      @(negedge clk); go = 1; cs = 0; cp = 0;
      @(negedge clk); go = 1; cs = 1; cp = 1;
      @(negedge clk); go = 0;
      repeat (10 * dv) begin @(negedge clk); if (done || busy || scl_oe) seen = 1; end
      chk("R8 idle ignore activity", seen, 0);
      chk("R8 idle ignore starts", starts, 0);
      chk("R8 idle ignore mode", int'(mode), 0);

      // R2 START + write address
      ack_en = 1;
      run_go(1, 0, 0, 8'h54, 0, n, d2);
      chk("R2 start time", n, 19 * dv);
      chk("R2 mode tx", int'(mode), 1);
      chk("R2 byte seen", int'(last_byte), 'h54);
      chk("R2 one start", starts, 1);
      chk("R5 ack low", int'(ack_rx), 0);
      chk("R10 done single", d2, 0);

      // R3 plain byte, slave does not acknowledge
      ack_en = 0;
      run_go(0, 0, 0, 8'hC3, 0, n, d2);
      chk("R3 plain time", n, 18 * dv);
      chk("R3 byte seen", int'(last_byte), 'hC3);
      chk("R3 no new start", starts, 1);
      chk("R3 no stop", stops, 0);
      chk("R5 nack high", int'(ack_rx), 1);

      // R8 go pulsed mid-byte is ignored
      ack_en = 1;
      run_go(0, 0, 0, 8'h5A, 5 * dv, n, d2);
      chk("R8 busy time", n, 18 * dv);
      chk("R8 busy byte", int'(last_byte), 'h5A);
      seen = 0;
      repeat (30 * dv) begin @(negedge clk); if (done || busy) seen = 1; end
      chk("R8 busy ignore activity", seen, 0);
      chk("R8 busy ignore starts", starts, 1);

      // R4 repeated START with read address
      slave_tx = 8'h96;
      run_go(1, 0, 0, 8'h55, 0, n, d2);
      chk("R4 restart time", n, 21 * dv);
      chk("R4 starts", starts, 2);
      chk("R4 no stop", stops, 0);
      chk("R4 mode rx", int'(mode), 2);

      // R6 receive with ACK
      run_go(0, 0, 0, 8'h00, 0, n, d2);
      chk("R6 rx time", n, 18 * dv);
      chk("R6 rx data", int'(rd_data), 'h96);
      chk("R6 master ack", int'(m_ack), 0);

      // R7 receive with STOP, nack bit clear, start bit set (ignored)
      slave_tx = 8'h3C;
      run_go(1, 1, 0, 8'h00, 0, n, d2);
      chk("R7 rx stop time", n, 21 * dv);
      chk("R7 rx stop data", int'(rd_data), 'h3C);
      chk("R7 forced nack", int'(m_ack), 1);
      chk("R7 stops", stops, 1);
      chk("R7 start ignored", starts, 2);
      chk("R7 mode idle", int'(mode), 0);
      chk("R7 lines free", int'(scl_oe | sda_oe | busy), 0);

      // R7 transmit with STOP
      run_go(1, 0, 0, 8'hA4, 0, n, d2);
      chk("R2 second start time", n, 19 * dv);
      chk("R2 second mode", int'(mode), 1);
      run_go(1, 1, 0, 8'hE7, 0, n, d2);
      chk("R7 tx stop time", n, 21 * dv);
      chk("R7 tx byte", int'(last_byte), 'hE7);
      chk("R7 tx stops", stops, 2);
      chk("R7 tx starts", starts, 3);
      chk("R7 tx mode idle", int'(mode), 0);

      // R6 receive with NACK from control bit, then STOP
      slave_tx = 8'h81;
      run_go(1, 0, 0, 8'h55, 0, n, d2);
      chk("R2 read mode", int'(mode), 2);
      run_go(0, 0, 1, 8'h00, 0, n, d2);
      chk("R6 nack data", int'(rd_data), 'h81);
      chk("R6 nack driven", int'(m_ack), 1);
      chk("R6 no stop yet", stops, 2);
      run_go(0, 1, 1, 8'h00, 0, n, d2);
      chk("R7 released data", int'(rd_data), 'hFF);
      chk("R7 final stops", stops, 3);
      chk("R9 start count", starts, 4);
      chk("R7 final mode", int'(mode), 0);
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog act=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule